// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block sits next to a DRAM controller and tells it when refresh cycles are due. It does not drive any memory strobes. It only raises a refresh request, and the controller answers each refresh it actually runs with a one-cycle acknowledge. After reset the scheduler keeps the controller away from the memory for a 200 µs settling pause. It then asks for eight initialisation cycles. All of them are refreshes, which meets the rule that at least one initialisation cycle must be a refresh. Only after that does it open normal access.

In normal operation an interval timer produces one refresh demand per row slot. The slot length is the retention period divided by the number of rows: 64 ms for the standard part, or 256 ms when the extended-retention variant is selected. A low-power input switches the slot to a fixed 62.5 µs. Demands the controller has not yet served are held in a small saturating counter, so late refreshes are caught up instead of lost. When the controller reports that the memory has left its self-refreshing low-power state, the scheduler demands a back-to-back burst covering every row, and it keeps normal access closed until that burst is done.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `init_done`, `ref_req`, `burst_busy` and `access_en` are all 0.
- R2: After reset is released, `ref_req` stays 0 for exactly PAUSE = floor(200 × CLK_KHZ / 1000) rising edges and becomes 1 after edge number PAUSE.
- R3: After the pause, `ref_req` stays 1 until exactly INIT_CYCLES acknowledges have been taken. On the edge of the last one, `init_done` and `access_en` become 1 and `ref_req` drops.
- R4: Once `init_done` is 1, a refresh demand is created every IV = floor(P × CLK_KHZ / ROWS) cycles, where P = 64 with EXTENDED = 0 and P = 256 with EXTENDED = 1. The first demand shows on `ref_req` IV edges after the edge that set `init_done`.
- R5: While `lp_mode` is 1, the slot length is LP = floor(625 × CLK_KHZ / 10000) cycles (62.5 µs). A change of `lp_mode` takes effect at the next demand, which reloads the timer with the length then selected.
- R6: Unserved demands are counted up to OWED_MAX, and further demands while the count is full are absorbed. `ref_req` stays 1 until one acknowledge per counted demand has arrived. An acknowledge while `ref_req` is 0 has no effect.
- R7: A one-cycle `sr_exit` pulse while `init_done` is 1 sets `burst_busy` and clears `access_en` on the next edge. Both stay that way until ROWS acknowledges have been taken. A pulse during a burst restarts the full count of ROWS. A pulse before `init_done` is ignored.
- R8: Acknowledges are credited first to initialisation, then to the burst, then to the owed counter. Demands created during a burst stay owed after it, and `ref_req` remains 1 until they are served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ack | input | 1 | One-cycle pulse: the controller has issued one refresh |
| sr_exit | input | 1 | One-cycle pulse: the memory has left its self-refreshing state |
| lp_mode | input | 1 | Selects the 62.5 µs low-power refresh slot |
| init_done | output | 1 | Pause and initialisation cycles are complete |
| ref_req | output | 1 | At least one refresh is currently owed |
| burst_busy | output | 1 | A full-array refresh burst is in progress |
| access_en | output | 1 | Normal read and write accesses are allowed |

## Verification
A pause or initialisation counter that is off by one shifts the first rise of `ref_req`, or the rise of `init_done`, by a whole cycle, and the bench sees this at the exact edge it expects. A wrong slot length or a missed timer reload shows up at the very next refresh demand, because every rise of `ref_req` is compared against a precomputed cycle stamp. A wrong owed count or burst count only becomes visible when the controller stops acknowledging. So the bench withholds acknowledges and then counts exactly how many are needed before `ref_req` falls, or before `burst_busy` clears.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    INIT_WAIT = 2'd0,
    INIT_RUN  = 2'd1,
    INIT_OK   = 2'd2
  } init_state_e;

  function automatic int unsigned at_least_two(input int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction

  // cycles per row slot: retention period (ms) * kHz / rows
  function automatic int unsigned dist_interval(input int unsigned khz,
                                                input int unsigned rows,
                                                input bit          ext);
    int unsigned period_ms;
    period_ms = ext ? 256 : 64;
    return at_least_two((period_ms * khz) / rows);
  endfunction

  // 62.5 us expressed in cycles
  function automatic int unsigned lp_interval(input int unsigned khz);
    return at_least_two((625 * khz) / 10000);
  endfunction

  // 200 us expressed in cycles
  function automatic int unsigned pause_cycles(input int unsigned khz);
    int unsigned c;
    c = (200 * khz) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfs_init_seq.sv
module rfs_init_seq
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 50000,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);

  localparam int unsigned PW = width_for(PAUSE_CYC);
  localparam int unsigned IW = width_for(INIT_CYCLES);

  init_state_e     st;
  logic [PW-1:0]   pcnt;
  logic [IW-1:0]   icnt;
  logic            pause_end;
  logic            last_ack;

  assign pause_end = (st == INIT_WAIT) && (pcnt == PW'(PAUSE_CYC - 1));
  assign last_ack  = (st == INIT_RUN) && ack_i && (icnt == IW'(INIT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= INIT_WAIT;
      pcnt <= '0;
      icnt <= '0;
    end else begin
      case (st)
        INIT_WAIT: begin
          if (pause_end) st <= INIT_RUN;
          else           pcnt <= pcnt + 1'b1;
        end
        INIT_RUN: begin
          if (last_ack)   st <= INIT_OK;
          else if (ack_i) icnt <= icnt + 1'b1;
        end
        default: st <= INIT_OK;
      endcase
    end
  end

  assign req_o  = (st == INIT_RUN);
  assign done_o = (st == INIT_OK);

  // R2: the request appears only once the full pause has elapsed
  p_pause_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(pcnt) == PW'(PAUSE_CYC - 1));

  // R3: completion only on the acknowledge that closes the count
  p_init_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(ack_i) && $past(icnt) == IW'(INIT_CYCLES - 1)));

endmodule

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer
  import rfs_pkg::*;
#(
  parameter int unsigned DIST_CYC = 3906,
  parameter int unsigned LP_CYC   = 15625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lp_i,
  output logic tick_o
);

  localparam int unsigned TW = width_for(max_of(DIST_CYC, LP_CYC));

  logic [TW-1:0] cnt;
  logic [TW-1:0] reload_m1;
  logic          at_zero;

  assign reload_m1 = lp_i ? TW'(LP_CYC - 1) : TW'(DIST_CYC - 1);
  assign at_zero   = (cnt == '0);
  assign tick_o    = en_i && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!en_i)   cnt <= reload_m1;
    else if (at_zero) cnt <= reload_m1;
    else              cnt <= cnt - 1'b1;
  end

  // R4: no demand before initialisation has finished
  p_tick_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> en_i);

  // R5: every slot lasts at least two cycles, whichever length is selected
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/rfs_burst_ctr.sv
module rfs_burst_ctr
  import rfs_pkg::*;
#(
  parameter int unsigned ROWS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o
);

  localparam int unsigned BW = width_for(ROWS);

  logic [BW-1:0] cnt;

  assign busy_o = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (start_i)          cnt <= BW'(ROWS);
    else if (ack_i && busy_o)  cnt <= cnt - 1'b1;
  end

  // R7: a burst only ends on the acknowledge of its last row
  p_burst_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(ack_i) && $past(cnt) == BW'(1)));

  // R7: a start always leaves the counter busy
  p_burst_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr
  import rfs_pkg::*;
#(
  parameter int unsigned OWED_MAX = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ack_i,
  output logic owed_o
);

  localparam int unsigned OW = width_for(OWED_MAX);

  logic [OW-1:0] cnt;
  logic          full;
  logic          serve;

  assign full   = (cnt == OW'(OWED_MAX));
  assign owed_o = (cnt != '0);
  assign serve  = ack_i && owed_o;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({tick_i, serve})
        2'b10:   if (!full) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: the owed count never exceeds its limit
  p_owed_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OW'(OWED_MAX));

  // R6: the count only grows on a demand
  p_owed_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> cnt <= $past(cnt));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfs_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 250000,
  parameter int unsigned ROWS        = 4096,
  parameter bit          EXTENDED    = 1'b0,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned OWED_MAX    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  input  logic sr_exit,
  input  logic lp_mode,
  output logic init_done,
  output logic ref_req,
  output logic burst_busy,
  output logic access_en
);

  localparam int unsigned DIST_CYC  = dist_interval(CLK_KHZ, ROWS, EXTENDED);
  localparam int unsigned LP_CYC    = lp_interval(CLK_KHZ);
  localparam int unsigned PAUSE_CYC = pause_cycles(CLK_KHZ);

  logic init_req;
  logic tick;
  logic owed;
  logic burst_start;
  logic ack_init;
  logic ack_burst;
  logic ack_owed;

  // acknowledge routing: initialisation, then burst, then owed demands
  assign ack_init    = ref_ack && init_req;
  assign ack_burst   = ref_ack && !init_req && burst_busy;
  assign ack_owed    = ref_ack && !init_req && !burst_busy;
  assign burst_start = sr_exit && init_done;

  rfs_init_seq #(
    .PAUSE_CYC  (PAUSE_CYC),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .ack_i (ack_init),
    .req_o (init_req),
    .done_o(init_done)
  );

  rfs_interval_timer #(
    .DIST_CYC(DIST_CYC),
    .LP_CYC  (LP_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (init_done),
    .lp_i  (lp_mode),
    .tick_o(tick)
  );

  rfs_burst_ctr #(
    .ROWS(ROWS)
  ) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(burst_start),
    .ack_i  (ack_burst),
    .busy_o (burst_busy)
  );

  rfs_owed_ctr #(
    .OWED_MAX(OWED_MAX)
  ) u_owed (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(tick),
    .ack_i (ack_owed),
    .owed_o(owed)
  );

  assign ref_req   = init_req || burst_busy || owed;
  assign access_en = init_done && !burst_busy;

  // R8: an acknowledge during initialisation never reaches the burst counter
  p_ack_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> !burst_busy);

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;

  localparam int unsigned T_KHZ  = 1000;
  localparam int unsigned T_ROWS = 256;
  localparam int unsigned T_OWED = 4;
  localparam int unsigned PAUSE  = 200 * T_KHZ / 1000;
  localparam int unsigned IV     = 64 * T_KHZ / T_ROWS;
  localparam int unsigned XIV    = 256 * T_KHZ / T_ROWS;
  localparam int unsigned LPIV   = 625 * T_KHZ / 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ack = 1'b0, sr_exit = 1'b0, lp_mode = 1'b0;
  logic init_done, ref_req, burst_busy, access_en;
  logic ack_x = 1'b0;
  logic init_done_x, req_x, busy_x, acc_x;

  int unsigned cyc = 0;
  int unsigned checks = 0;
  int unsigned errors = 0;

  typedef struct { int unsigned t; string tag; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  dram_refresh_sched #(.CLK_KHZ(T_KHZ), .ROWS(T_ROWS), .EXTENDED(1'b0),
                       .INIT_CYCLES(8), .OWED_MAX(T_OWED)) uut (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .sr_exit(sr_exit),
    .lp_mode(lp_mode), .init_done(init_done), .ref_req(ref_req),
    .burst_busy(burst_busy), .access_en(access_en));

  dram_refresh_sched #(.CLK_KHZ(T_KHZ), .ROWS(T_ROWS), .EXTENDED(1'b1),
                       .INIT_CYCLES(8), .OWED_MAX(T_OWED)) uut_ext (
    .clk(clk), .rst_n(rst_n), .ref_ack(ack_x), .sr_exit(1'b0),
    .lp_mode(1'b0), .init_done(init_done_x), .ref_req(req_x),
    .burst_busy(busy_x), .access_en(acc_x));

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_exp(input int unsigned t, input string tag);
    exp_t e;
    e.t = t;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic ack1();
    @(negedge clk) ref_ack = 1'b1;
    @(negedge clk) ref_ack = 1'b0;
  endtask

  task automatic wait_cyc(input int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_req_ack();
    while (!ref_req) @(negedge clk);
    ack1();
  endtask

  task automatic pulse_exit();
    @(negedge clk) sr_exit = 1'b1;
    @(negedge clk) sr_exit = 1'b0;
  endtask

  // monitor: every rise of ref_req is compared with the next expected stamp
  logic req_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ref_req && !req_prev && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.tag, " request rise cycle"}, cyc, e.t);
    end
    req_prev <= ref_req;
  end

  // extended-retention instance: acknowledges every request on its own
  int unsigned e1 = 0, x_first = 0;
  always @(negedge clk) begin
    ack_x <= rst_n && req_x && !ack_x;
    if (rst_n) begin
      if (init_done_x && e1 == 0) e1 <= cyc;
      if (e1 != 0 && x_first == 0 && req_x) x_first <= cyc;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned e0, s, l, n, exp_owed;
    push_exp(PAUSE, "R2");
    repeat (5) @(negedge clk);
    check("R1 init_done in reset", init_done, 0);
    check("R1 ref_req in reset", ref_req, 0);
    check("R1 burst_busy in reset", burst_busy, 0);
    check("R1 access_en in reset", access_en, 0);
    rst_n = 1'b1;

    wait_cyc(50);
    pulse_exit();
    wait_cyc(PAUSE - 1);
    check("R2 ref_req before pause end", ref_req, 0);
    check("R7 exit pulse before init ignored", burst_busy, 0);
    wait_cyc(PAUSE);
    check("R2 ref_req at pause end", ref_req, 1);

    for (int i = 0; i < 7; i++) begin
      ack1();
      @(negedge clk);
    end
    check("R3 init_done after 7 acks", init_done, 0);
    check("R3 ref_req held during init", ref_req, 1);
    ack1();
    e0 = cyc;
    check("R3 init_done after 8 acks", init_done, 1);
    check("R3 access_en after init", access_en, 1);
    check("R3 ref_req drops after init", ref_req, 0);

    push_exp(e0 + IV, "R4");
    push_exp(e0 + 2 * IV, "R4");
    push_exp(e0 + 3 * IV, "R4");
    push_exp(e0 + 4 * IV, "R6");
    for (int i = 0; i < 3; i++) wait_req_ack();

    // R6: withhold acknowledges over six slots, limit is four
    wait_cyc(e0 + 9 * IV + 10);
    check("R6 ref_req while owed", ref_req, 1);
    for (int i = 0; i < 3; i++) ack1();
    check("R6 still owed after 3 acks", ref_req, 1);
    ack1();
    check("R6 cleared after limit acks", ref_req, 0);
    ack1();
    @(negedge clk);
    check("R6 stray ack has no effect", ref_req, 0);
    push_exp(e0 + 10 * IV, "R6");
    wait_req_ack();
    @(negedge clk);
    check("R6 single ack clears next demand", ref_req, 0);

    wait_cyc(e0 + 10 * IV + 5);
    lp_mode = 1'b1;
    push_exp(e0 + 11 * IV, "R5");
    push_exp(e0 + 11 * IV + LPIV, "R5");
    push_exp(e0 + 11 * IV + 2 * LPIV, "R5");
    for (int i = 0; i < 3; i++) wait_req_ack();
    wait_cyc(e0 + 11 * IV + 2 * LPIV + 6);
    lp_mode = 1'b0;
    push_exp(e0 + 11 * IV + 3 * LPIV, "R5");
    push_exp(e0 + 12 * IV + 3 * LPIV, "R5");
    for (int i = 0; i < 2; i++) wait_req_ack();

    // burst with a restart partway through
    wait_cyc(e0 + 12 * IV + 3 * LPIV + 10);
    push_exp(cyc + 2, "R7");
    pulse_exit();
    s = cyc;
    check("R7 burst_busy after exit", burst_busy, 1);
    check("R7 access_en closed in burst", access_en, 0);
    for (int i = 0; i < 100; i++) ack1();
    pulse_exit();
    for (int i = 0; i < T_ROWS - 1; i++) ack1();
    check("R7 burst restarted, still busy", burst_busy, 1);
    check("R7 access_en still closed", access_en, 0);
    ack1();
    l = cyc;
    check("R7 burst_busy after full count", burst_busy, 0);
    check("R7 access_en reopened", access_en, 1);

    n = 0;
    for (int k = 0; k < 40; k++) begin
      int unsigned t;
      t = e0 + (12 + k) * IV + 3 * LPIV;
      if (t >= s && t <= l) n++;
    end
    exp_owed = (n > T_OWED) ? T_OWED : n;
    check("R8 request after burst with owed demands", ref_req, (exp_owed > 0) ? 1 : 0);
    n = 0;
    while (ref_req && n < 12) begin
      ack1();
      n++;
    end
    check("R8 acks needed for demands owed from burst", n, exp_owed);

    check("R4 extended slot length", x_first - e1, XIV);
    check("R4 all expected request rises seen", exp_q.size(), 0);
    finish_run();
  end

endmodule